// File: doc/BRIEF.md
# Registered Lookup-Cell Grid Fabric

The block is a rectangular array of identical logic cells. Each cell has four single-bit neighbour links in, one from each orthogonal side, and four single-bit links out, one to each side. A cell's four outputs come from a registered lookup: the 4-bit vector of its inputs selects one nibble of a 64-bit per-cell table, and that nibble is captured in the cell's output register on the next clock edge. There are no long wires and no dedicated routing. To carry a signal across the array, a cell is programmed as a wire that copies its inputs to its outputs. Each hop therefore costs exactly one clock cycle, and every cell is a pipeline stage.

The array boundary connects to four edge input buses and four edge output buses, one of each per side. New edge data can be applied on every cycle, and results stream out at the same rate after the pipeline latency. All tables are loaded through one serial shift chain that runs through every cell. While loading, the cell registers are held at zero. The serial tail is brought out so that grids can be daisy-chained.

Top module: `lut_grid_fabric`

## Requirements
- R1: While `rst` is high on a rising edge, every cell output register becomes 0, so all four edge output buses read 0 on the following cycle. `rst` does not alter the loaded tables.
- R2: With `cfgLoad` high, each edge shifts `cfgIn` into a chain of ROWS*COLS*64 bits. Cell index is row*COLS+col. Within a cell, the table holds bit b at position b, and a shift moves bit b into position b-1. The first bit shifted in after a full load ends up in bit 0 of the highest-index cell. The last bit ends up in bit 63 of cell 0. `cfgOut` always shows bit 0 of the highest-index cell.
- R3: While `cfgLoad` is high, all cell output registers are held at 0 whatever the edge inputs are.
- R4: While `cfgLoad` is low, the tables do not change, including across reset.
- R5: A cell forms the index idx = {west, south, east, north} from its inputs and loads table bits [4*idx+3 : 4*idx] into its output register.
- R6: Output bit 0 drives north, bit 1 east, bit 2 south and bit 3 west. Input bit k comes from the neighbour in direction k.
- R7: Cells on the boundary take missing neighbours from `northIn[col]`, `southIn[col]`, `westIn[row]` and `eastIn[row]`. The edge outputs are the boundary cells' outward bits: `northOut[col]` from row 0, `southOut[col]` from row ROWS-1, `westOut[row]` from column 0, `eastOut[row]` from column COLS-1.
- R8: With every cell of a row set as a crossing wire, a bit on `westIn[row]` appears on `eastOut[row]` exactly COLS cycles later. A bit on `northIn[col]` likewise appears on `southOut[col]` exactly ROWS cycles later.
- R9: A new edge value accepted on every cycle emerges on every cycle, in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of cell output registers |
| cfgLoad | input | 1 | Shift enable for the configuration chain |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial tail of the configuration chain |
| northIn | input | COLS | Inputs into the north side of row 0 |
| eastIn | input | ROWS | Inputs into the east side of column COLS-1 |
| southIn | input | COLS | Inputs into the south side of row ROWS-1 |
| westIn | input | ROWS | Inputs into the west side of column 0 |
| northOut | output | COLS | North outputs of row 0 |
| eastOut | output | ROWS | East outputs of column COLS-1 |
| southOut | output | COLS | South outputs of row ROWS-1 |
| westOut | output | ROWS | West outputs of column 0 |

## Verification
A 4x4 grid is programmed entirely as crossing wires and fed a fresh random bit on every edge input every cycle. Delay, order, dropped bits and swapped directions each show up as a mismatch on the opposite edge. Reloading with the far corner set to XOR its four inputs mixes paths of different lengths. This exposes any error in hop counts or in the chain's cell order, which `cfgOut` also confirms as it replays the previous image. A separate 1x1 grid is swept over all sixteen input combinations under two arithmetic tables. This separates index bit order from output bit order.

// File: rtl/grid_pkg.sv
package grid_pkg;
  localparam int DIRS = 4;
  localparam int CFG_BITS = DIRS << DIRS;
  localparam int SEL_W = $clog2(CFG_BITS);

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef struct packed {
    logic shiftCfg;
    logic clearState;
  } grid_ctrl_t;
endpackage

// File: rtl/grid_ctrl.sv
module grid_ctrl
  import grid_pkg::*;
(
  input  logic       rst,
  input  logic       cfgLoad,
  output grid_ctrl_t strobes
);
  always_comb begin
    strobes.shiftCfg   = cfgLoad;
    strobes.clearState = rst | cfgLoad;
  end
endmodule

// File: rtl/grid_cell.sv
module grid_cell
  import grid_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  grid_ctrl_t      strobes,
  input  logic            cfgShiftIn,
  output logic            cfgShiftOut,
  input  logic [DIRS-1:0] nbrIn,
  output logic [DIRS-1:0] cellOut
);
  logic [CFG_BITS-1:0] cfgQ;
  logic [DIRS-1:0]     stateQ;
  logic [DIRS-1:0]     nextState;
  logic [SEL_W-1:0]    nibbleBase;

  always_ff @(posedge clk) begin
    if (strobes.shiftCfg) cfgQ <= {cfgShiftIn, cfgQ[CFG_BITS-1:1]};
  end

  always_comb begin
    nibbleBase = SEL_W'(nbrIn) << $clog2(DIRS);
    nextState  = cfgQ[nibbleBase +: DIRS];
  end

  always_ff @(posedge clk) begin
    if (strobes.clearState) stateQ <= '0;
    else                    stateQ <= nextState;
  end

  assign cellOut     = stateQ;
  assign cfgShiftOut = cfgQ[0];

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftCfg |=> (cellOut == '0));

  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftCfg |=> $stable(cfgQ));

  assert_chain_shift_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftCfg |=> (cfgQ[CFG_BITS-2:0] == $past(cfgQ[CFG_BITS-1:1]))
                         && (cfgQ[CFG_BITS-1] == $past(cfgShiftIn)));
endmodule

// File: rtl/grid_array.sv
module grid_array
  import grid_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  grid_ctrl_t      strobes,
  input  logic            cfgIn,
  output logic            cfgOut,
  input  logic [COLS-1:0] northIn,
  input  logic [ROWS-1:0] eastIn,
  input  logic [COLS-1:0] southIn,
  input  logic [ROWS-1:0] westIn,
  output logic [COLS-1:0] northOut,
  output logic [ROWS-1:0] eastOut,
  output logic [COLS-1:0] southOut,
  output logic [ROWS-1:0] westOut
);
  localparam int NCELL = ROWS * COLS;

  logic [DIRS-1:0] outQ [ROWS][COLS];
  logic [DIRS-1:0] nbr  [ROWS][COLS];
  logic            chain [NCELL+1];

  assign chain[0] = cfgIn;
  assign cfgOut   = chain[NCELL];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (r == 0) begin : g_nEdge
        assign nbr[r][c][DIR_N] = northIn[c];
      end else begin : g_nCell
        assign nbr[r][c][DIR_N] = outQ[r-1][c][DIR_S];
      end
      if (r == ROWS-1) begin : g_sEdge
        assign nbr[r][c][DIR_S] = southIn[c];
      end else begin : g_sCell
        assign nbr[r][c][DIR_S] = outQ[r+1][c][DIR_N];
      end
      if (c == 0) begin : g_wEdge
        assign nbr[r][c][DIR_W] = westIn[r];
      end else begin : g_wCell
        assign nbr[r][c][DIR_W] = outQ[r][c-1][DIR_E];
      end
      if (c == COLS-1) begin : g_eEdge
        assign nbr[r][c][DIR_E] = eastIn[r];
      end else begin : g_eCell
        assign nbr[r][c][DIR_E] = outQ[r][c+1][DIR_W];
      end

      grid_cell u_cell (
        .clk        (clk),
        .rst        (rst),
        .strobes    (strobes),
        .cfgShiftIn (chain[r*COLS+c]),
        .cfgShiftOut(chain[r*COLS+c+1]),
        .nbrIn      (nbr[r][c]),
        .cellOut    (outQ[r][c])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colEdge
    assign northOut[c] = outQ[0][c][DIR_N];
    assign southOut[c] = outQ[ROWS-1][c][DIR_S];
  end
  for (genvar r = 0; r < ROWS; r++) begin : g_rowEdge
    assign westOut[r] = outQ[r][0][DIR_W];
    assign eastOut[r] = outQ[r][COLS-1][DIR_E];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (northOut == '0 && southOut == '0 && eastOut == '0 && westOut == '0));
endmodule

// File: rtl/lut_grid_fabric.sv
module lut_grid_fabric
  import grid_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgLoad,
  input  logic            cfgIn,
  output logic            cfgOut,
  input  logic [COLS-1:0] northIn,
  input  logic [ROWS-1:0] eastIn,
  input  logic [COLS-1:0] southIn,
  input  logic [ROWS-1:0] westIn,
  output logic [COLS-1:0] northOut,
  output logic [ROWS-1:0] eastOut,
  output logic [COLS-1:0] southOut,
  output logic [ROWS-1:0] westOut
);
  grid_ctrl_t strobes;

  grid_ctrl u_ctrl (
    .rst    (rst),
    .cfgLoad(cfgLoad),
    .strobes(strobes)
  );

  grid_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cfgIn   (cfgIn),
    .cfgOut  (cfgOut),
    .northIn (northIn),
    .eastIn  (eastIn),
    .southIn (southIn),
    .westIn  (westIn),
    .northOut(northOut),
    .eastOut (eastOut),
    .southOut(southOut),
    .westOut (westOut)
  );
endmodule

// File: tb/lut_grid_fabric_tb.sv
`timescale 1ns/1ps
module lut_grid_fabric_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int NCELL = ROWS * COLS;
  localparam int HLEN = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgLoad = 1'b0, cfgIn = 1'b0, cfgOut;
  logic [COLS-1:0] northIn = '0, southIn = '0, northOut, southOut;
  logic [ROWS-1:0] eastIn = '0, westIn = '0, eastOut, westOut;

  logic oneLoad = 1'b0, oneCfgIn = 1'b0, oneCfgOut;
  logic [0:0] oneN = '0, oneE = '0, oneS = '0, oneW = '0;
  logic [0:0] oneNo, oneEo, oneSo, oneWo;

  int nCmp = 0;
  int nBad = 0;

  logic [63:0] cfgNext [NCELL];
  logic [63:0] cfgPrev [NCELL];
  logic [COLS-1:0] hN [HLEN];
  logic [COLS-1:0] hS [HLEN];
  logic [ROWS-1:0] hE [HLEN];
  logic [ROWS-1:0] hW [HLEN];

  always #2.5 clk = ~clk;

  lut_grid_fabric #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgIn(cfgIn), .cfgOut(cfgOut),
    .northIn(northIn), .eastIn(eastIn), .southIn(southIn), .westIn(westIn),
    .northOut(northOut), .eastOut(eastOut), .southOut(southOut), .westOut(westOut)
  );

  lut_grid_fabric #(.ROWS(1), .COLS(1)) u_one (
    .clk(clk), .rst(rst), .cfgLoad(oneLoad), .cfgIn(oneCfgIn), .cfgOut(oneCfgOut),
    .northIn(oneN), .eastIn(oneE), .southIn(oneS), .westIn(oneW),
    .northOut(oneNo), .eastOut(oneEo), .southOut(oneSo), .westOut(oneWo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] wireNib(input int idx);
    logic [3:0] i;
    i = 4'(idx);
    return {i[1], i[0], i[3], i[2]};
  endfunction

  function automatic logic [3:0] xorNib(input int idx);
    return {4{^(4'(idx))}};
  endfunction

  function automatic logic [63:0] buildTable(input int kind);
    logic [63:0] t;
    for (int i = 0; i < 16; i++) begin
      case (kind)
        0: t[4*i +: 4] = wireNib(i);
        1: t[4*i +: 4] = xorNib(i);
        2: t[4*i +: 4] = 4'((i * 7 + 3) & 15);
        default: t[4*i +: 4] = 4'((i * 11 + 5) & 15);
      endcase
    end
    return t;
  endfunction

  function automatic logic getN(input int k, input int c);
    return (k < 0) ? 1'b0 : hN[k][c];
  endfunction
  function automatic logic getS(input int k, input int c);
    return (k < 0) ? 1'b0 : hS[k][c];
  endfunction
  function automatic logic getE(input int k, input int r);
    return (k < 0) ? 1'b0 : hE[k][r];
  endfunction
  function automatic logic getW(input int k, input int r);
    return (k < 0) ? 1'b0 : hW[k][r];
  endfunction

  // Corner cell (ROWS-1, COLS-1) register value at sample k when set to XOR.
  function automatic logic cornerX(input int k);
    if (k <= 0) return 1'b0;
    return getE(k-1, ROWS-1) ^ getS(k-1, COLS-1) ^ getN(k-ROWS, COLS-1) ^ getW(k-COLS, ROWS-1);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    northIn = '1; southIn = '1; eastIn = '1; westIn = '1;
    repeat (2) @(negedge clk);
    check("R1 northOut in reset", 32'(northOut), 32'h0);
    check("R1 eastOut in reset", 32'(eastOut), 32'h0);
    check("R1 southOut in reset", 32'(southOut), 32'h0);
    check("R1 westOut in reset", 32'(westOut), 32'h0);
    rst = 1'b0;
    northIn = '0; southIn = '0; eastIn = '0; westIn = '0;
  endtask

  task automatic loadGrid(input bit checkTail);
    int tailBad;
    tailBad = 0;
    for (int i = NCELL-1; i >= 0; i--) begin
      for (int b = 0; b < 64; b++) begin
        @(negedge clk);
        if (checkTail && cfgOut !== cfgPrev[i][b]) tailBad++;
        if (b == 5) begin
          check("R3 edge outputs held during load",
                32'({northOut, eastOut, southOut, westOut}), 32'h0);
        end
        cfgLoad = 1'b1;
        cfgIn = cfgNext[i][b];
        northIn = '1; southIn = '1; eastIn = '1; westIn = '1;
      end
    end
    @(negedge clk);
    cfgLoad = 1'b0;
    cfgIn = 1'b0;
    northIn = '0; southIn = '0; eastIn = '0; westIn = '0;
    if (checkTail) check("R2 cfgOut replays previous image", 32'(tailBad), 32'h0);
    for (int i = 0; i < NCELL; i++) cfgPrev[i] = cfgNext[i];
  endtask

  task automatic runStream(input int steps, input bit xorMode);
    logic [ROWS-1:0] expE, expW;
    logic [COLS-1:0] expN, expS;
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      for (int r = 0; r < ROWS; r++) begin
        expE[r] = getW(k-COLS, r);
        expW[r] = getE(k-COLS, r);
      end
      for (int c = 0; c < COLS; c++) begin
        expS[c] = getN(k-ROWS, c);
        expN[c] = getS(k-ROWS, c);
      end
      if (xorMode) begin
        expE[ROWS-1] = cornerX(k);
        expS[COLS-1] = cornerX(k);
        expW[ROWS-1] = cornerX(k-(COLS-1));
        expN[COLS-1] = cornerX(k-(ROWS-1));
      end
      check(xorMode ? "R5 eastOut with XOR corner" : "R8 eastOut west-to-east wire", 32'(eastOut), 32'(expE));
      check(xorMode ? "R2 westOut after reload" : "R9 westOut east-to-west stream", 32'(westOut), 32'(expW));
      check(xorMode ? "R5 southOut with XOR corner" : "R8 southOut north-to-south wire", 32'(southOut), 32'(expS));
      check(xorMode ? "R7 northOut after reload" : "R7 northOut south-to-north wire", 32'(northOut), 32'(expN));
      northIn = COLS'($urandom); southIn = COLS'($urandom);
      eastIn = ROWS'($urandom); westIn = ROWS'($urandom);
      hN[k] = northIn; hS[k] = southIn; hE[k] = eastIn; hW[k] = westIn;
    end
  endtask

  task automatic sweepOne(input logic [63:0] tbl, input string tag);
    for (int b = 0; b < 64; b++) begin
      @(negedge clk);
      oneLoad = 1'b1;
      oneCfgIn = tbl[b];
    end
    @(negedge clk);
    oneLoad = 1'b0;
    for (int idx = 0; idx <= 16; idx++) begin
      @(negedge clk);
      if (idx > 0) begin
        check({tag, " R5 nibble select"}, 32'({oneWo, oneSo, oneEo, oneNo}), 32'(tbl[4*(idx-1) +: 4]));
        check({tag, " R6 east bit"}, 32'(oneEo), 32'(tbl[4*(idx-1) + 1]));
      end
      if (idx < 16) begin
        oneN = idx[0]; oneE = idx[1]; oneS = idx[2]; oneW = idx[3];
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs after reset", 32'({northOut, eastOut, southOut, westOut}), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NCELL; i++) cfgNext[i] = buildTable(0);
    loadGrid(1'b0);
    runStream(100, 1'b0);

    doReset();
    runStream(60, 1'b0);  // R4: wire image still present after reset

    for (int i = 0; i < NCELL; i++) cfgNext[i] = buildTable(0);
    cfgNext[NCELL-1] = buildTable(1);
    loadGrid(1'b1);
    runStream(100, 1'b1);

    for (int i = 0; i < NCELL; i++) cfgNext[i] = buildTable(0);
    loadGrid(1'b1);
    runStream(40, 1'b0);

    sweepOne(buildTable(2), "table A");
    sweepOne(buildTable(3), "table B");
    sweepOne(buildTable(1), "xor table");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule